// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Controller

This controller sits between a simple request port and an external synchronous SRAM that moves two data words per address, one on each half of the clock. A user presents a single read or write request with a valid/ready handshake. The request carries a direction flag, a word-pair address and, for writes, two data words. The controller turns each accepted request into one command cycle on the shared address bus, with an active-low read or write strobe. A write is followed by one cycle of driven data, carrying one word on the rising half and one on the falling half. A read is followed by capture of the two returned words. Read results come back on a response port in the order they were requested, and always as logical word 0 then word 1.

The memory side is modelled as per-phase buses. Write data is split into a rising-half bus and a falling-half bus, with an output enable for the shared data pins. Read data likewise arrives on separate rising-half and falling-half input buses. Read and write commands may only use alternate clock edges, so each cycle is either a read slot or a write slot. The controller also leaves at least one idle cycle between any two commands. This turns the bus around and keeps driven write data and returning read data apart. Two parameters choose the memory flavour. One sets where a burst starts: at the word picked by the address LSB, or always at word 0. The other sets the read latency: one and a half cycles, or one cycle.

Top module: `sram_b2_ctrl`

## Requirements
- R1: While reset is held and until the first request is accepted, `mem_rd_n` and `mem_wr_n` are 1, `mem_oe` is 0 and `rsp_valid` is 0.
- R2: Bus cycles alternate between read slots and write slots. When idle, `req_ready` toggles every cycle, and for a given cycle it is 1 for exactly one value of `req_we`. A read strobe is never followed two cycles later by a write strobe, and a write strobe is never followed two cycles later by a read strobe.
- R3: In a cycle in which a strobe is low, `req_ready` is 0 for both request types, so the next cycle carries no command.
- R4: A request accepted at an edge puts its strobe low and `req_addr` on `mem_addr` in the following cycle. For a write, `mem_oe` is 1 in the cycle after that strobe and only then.
- R5: With `LSB_START`=1 the first bus word of a burst (`mem_wdq_rise`) is the logical word selected by address bit 0, and the second is the other word. With `LSB_START`=0 the first bus word is always logical word 0 (`req_wd0`).
- R6: With `HALF_LAT`=1 the first bus word of a read is taken from `mem_rdq_fall` in the cycle after the read strobe, and the second from `mem_rdq_rise` in the cycle after that. `rsp_valid` is then 1 three cycles after the strobe cycle. With `HALF_LAT`=0 both words are taken in the cycle after the strobe, the first from `mem_rdq_rise` and the second from `mem_rdq_fall`, and `rsp_valid` is 1 two cycles after the strobe cycle.
- R7: Responses return in request order. `rsp_rd0`/`rsp_rd1` are logical words 0 and 1 of the pair, whatever the starting word was.
- R8: `mem_oe` is 0 in the two cycles that follow a read strobe.
- R9: A cycle with no accepted request is followed by a cycle with both strobes high. The two strobes are never low together.
- R10: Data written through the controller is read back unchanged through it, for both values of the address LSB on either access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; commands are launched on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle (depends on `req_we`) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address; bit 0 selects the starting word of the pair |
| req_wd0 | input | DW | Logical word 0 of write data |
| req_wd1 | input | DW | Logical word 1 of write data |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_rd0 | output | DW | Logical word 0 of read data |
| rsp_rd1 | output | DW | Logical word 1 of read data |
| mem_addr | output | AW | Shared address bus to the memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_oe | output | 1 | Drive enable for the shared data pins |
| mem_wdq_rise | output | DW | Write word for the rising half of the cycle |
| mem_wdq_fall | output | DW | Write word for the falling half of the cycle |
| mem_rdq_rise | input | DW | Read word arriving in the rising half of the cycle |
| mem_rdq_fall | input | DW | Read word arriving in the falling half of the cycle |

## Verification
The hardest condition to reach is a pair of commands that have to be held apart to avoid a collision on the data pins. This happens when a read follows a write, or a write follows a read, as tightly as the slots allow. The stimulus reaches it by placing requests back to back as soon as the previous one has been accepted. It then probes `req_ready` for the opposite type during the strobe cycle itself. A cycle-level memory model with both latency options sits behind two controller instances, one wide with one-and-a-half-cycle reads and one narrow with one-cycle reads. The model flags any cycle in which driven data overlaps returning read data. Its array is also preloaded directly, so that the start-word reordering on reads is seen apart from the reordering on writes.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  // Kind of bus cycle on the shared address bus.
  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;

  // Number of data words moved per address.
  localparam int unsigned WORDS_PER_BURST = 2;

endpackage

// File: rtl/sram_b2_slot_arb.sv
module sram_b2_slot_arb
  import sram_b2_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_n,
  output logic          mem_wr_n
);

  slot_e         slot_q, slot_d;
  slot_e         want;
  logic          rd_n_q, rd_n_d;
  logic          wr_n_q, wr_n_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic          busy;
  logic          accept;

  always_comb begin
    busy      = !rd_n_q || !wr_n_q;
    slot_d    = (slot_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
    want      = req_we ? SLOT_WR : SLOT_RD;
    // A command taken now appears in the next cycle, whose slot is slot_d.
    req_ready = !busy && (slot_d == want);
    accept    = req_valid && req_ready;
    acc_rd    = accept && !req_we;
    acc_wr    = accept && req_we;
    rd_n_d    = !acc_rd;
    wr_n_d    = !acc_wr;
    addr_en   = accept;
    addr_d    = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_RD;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else begin
      slot_q <= slot_d;
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd_n = rd_n_q;
  assign mem_wr_n = wr_n_q;

endmodule

// File: rtl/sram_b2_wr_path.sv
module sram_b2_wr_path #(
  parameter int unsigned DW        = 36,
  parameter bit          LSB_START = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          lsb,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  output logic          mem_oe,
  output logic [DW-1:0] mem_wdq_rise,
  output logic [DW-1:0] mem_wdq_fall
);

  logic          swap;
  logic          pend_v_q;
  logic [DW-1:0] pend_rise_q, pend_rise_d;
  logic [DW-1:0] pend_fall_q, pend_fall_d;
  logic          oe_q;
  logic [DW-1:0] rise_q, rise_d;
  logic [DW-1:0] fall_q, fall_d;

  generate
    if (LSB_START) begin : g_lsb_start
      assign swap = lsb;
    end else begin : g_zero_start
      assign swap = 1'b0;
    end
  endgenerate

  always_comb begin
    pend_rise_d = swap ? wd1 : wd0;
    pend_fall_d = swap ? wd0 : wd1;
    rise_d      = pend_v_q ? pend_rise_q : '0;
    fall_d      = pend_v_q ? pend_fall_q : '0;
  end

  // Stage held during the command cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_rise_q <= '0;
      pend_fall_q <= '0;
    end else begin
      pend_v_q <= acc_wr;
      if (acc_wr) begin
        pend_rise_q <= pend_rise_d;
        pend_fall_q <= pend_fall_d;
      end
    end
  end

  // Stage driven on the pins during the data cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      oe_q   <= pend_v_q;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign mem_oe       = oe_q;
  assign mem_wdq_rise = rise_q;
  assign mem_wdq_fall = fall_q;

endmodule

// File: rtl/sram_b2_rd_path.sv
module sram_b2_rd_path #(
  parameter int unsigned DW        = 36,
  parameter bit          LSB_START = 1'b1,
  parameter bit          HALF_LAT  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_rd,
  input  logic          lsb,
  input  logic [DW-1:0] mem_rdq_rise,
  input  logic [DW-1:0] mem_rdq_fall,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rd0,
  output logic [DW-1:0] rsp_rd1
);

  logic          swap;
  logic          p0_v_q, p0_sw_q;
  logic          p1_v_q, p1_sw_q;
  logic          fin_v, fin_sw;
  logic [DW-1:0] fin_first, fin_second;
  logic          rsp_v_q;
  logic [DW-1:0] rd0_q, rd0_d;
  logic [DW-1:0] rd1_q, rd1_d;

  generate
    if (LSB_START) begin : g_lsb_start
      assign swap = lsb;
    end else begin : g_zero_start
      assign swap = 1'b0;
    end
  endgenerate

  // p0: command cycle, p1: cycle after the memory took the address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_v_q  <= 1'b0;
      p0_sw_q <= 1'b0;
      p1_v_q  <= 1'b0;
      p1_sw_q <= 1'b0;
    end else begin
      p0_v_q  <= acc_rd;
      p0_sw_q <= swap;
      p1_v_q  <= p0_v_q;
      p1_sw_q <= p0_sw_q;
    end
  end

  generate
    if (HALF_LAT) begin : g_half
      logic          p2_v_q, p2_sw_q;
      logic [DW-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p2_v_q  <= 1'b0;
          p2_sw_q <= 1'b0;
          hold_q  <= '0;
        end else begin
          p2_v_q  <= p1_v_q;
          p2_sw_q <= p1_sw_q;
          if (p1_v_q) begin
            hold_q <= mem_rdq_fall;
          end
        end
      end

      always_comb begin
        fin_v      = p2_v_q;
        fin_sw     = p2_sw_q;
        fin_first  = hold_q;
        fin_second = mem_rdq_rise;
      end
    end else begin : g_full
      always_comb begin
        fin_v      = p1_v_q;
        fin_sw     = p1_sw_q;
        fin_first  = mem_rdq_rise;
        fin_second = mem_rdq_fall;
      end
    end
  endgenerate

  always_comb begin
    rd0_d = fin_sw ? fin_second : fin_first;
    rd1_d = fin_sw ? fin_first  : fin_second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rd0_q   <= '0;
      rd1_q   <= '0;
    end else begin
      rsp_v_q <= fin_v;
      if (fin_v) begin
        rd0_q <= rd0_d;
        rd1_q <= rd1_d;
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rd0   = rd0_q;
  assign rsp_rd1   = rd1_q;

endmodule

// File: rtl/sram_b2_ctrl.sv
module sram_b2_ctrl #(
  parameter int unsigned AW        = 20,
  parameter int unsigned DW        = 36,
  parameter bit          LSB_START = 1'b1,
  parameter bit          HALF_LAT  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wd0,
  input  logic [DW-1:0] req_wd1,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rd0,
  output logic [DW-1:0] rsp_rd1,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          mem_oe,
  output logic [DW-1:0] mem_wdq_rise,
  output logic [DW-1:0] mem_wdq_fall,
  input  logic [DW-1:0] mem_rdq_rise,
  input  logic [DW-1:0] mem_rdq_fall
);

  logic rst_meta;
  logic rst_s;
  logic acc_rd;
  logic acc_wr;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  sram_b2_slot_arb #(
    .AW(AW)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n)
  );

  sram_b2_wr_path #(
    .DW        (DW),
    .LSB_START (LSB_START)
  ) u_wr (
    .clk          (clk),
    .rst_n        (rst_s),
    .acc_wr       (acc_wr),
    .lsb          (req_addr[0]),
    .wd0          (req_wd0),
    .wd1          (req_wd1),
    .mem_oe       (mem_oe),
    .mem_wdq_rise (mem_wdq_rise),
    .mem_wdq_fall (mem_wdq_fall)
  );

  sram_b2_rd_path #(
    .DW        (DW),
    .LSB_START (LSB_START),
    .HALF_LAT  (HALF_LAT)
  ) u_rd (
    .clk          (clk),
    .rst_n        (rst_s),
    .acc_rd       (acc_rd),
    .lsb          (req_addr[0]),
    .mem_rdq_rise (mem_rdq_rise),
    .mem_rdq_fall (mem_rdq_fall),
    .rsp_valid    (rsp_valid),
    .rsp_rd0      (rsp_rd0),
    .rsp_rd1      (rsp_rd1)
  );

endmodule

// File: rtl/sram_b2_ctrl_chk.sv
module sram_b2_ctrl_chk #(
  parameter bit HALF_LAT = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic mem_oe,
  input logic rsp_valid
);

  localparam int unsigned RSP_GAP = HALF_LAT ? 3 : 2;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (mem_rd_n && mem_wr_n));

  // R3
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |=> (mem_rd_n && mem_wr_n));

  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_rd_n && mem_wr_n));

  // R2
  rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |=> ##1 mem_wr_n);

  // R2
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |=> ##1 mem_rd_n);

  // R4
  wr_data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |=> mem_oe);

  // R4
  oe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> $past(!mem_wr_n));

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |=> !mem_oe ##1 !mem_oe);

  // R6
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_rd_n, RSP_GAP));

endmodule

bind sram_b2_ctrl sram_b2_ctrl_chk #(
  .HALF_LAT (HALF_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .mem_oe    (mem_oe),
  .rsp_valid (rsp_valid)
);

// File: tb/sram_b2_ctrl_test.sv
`timescale 1ns/1ps

// Cycle-level model of the burst-of-two memory with selectable read latency.
module sram_b2_mem_model #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter bit          LSB_START = 1'b1,
  parameter bit          HALF_LAT  = 1'b1
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          oe,
  input  logic [DW-1:0] wrise,
  input  logic [DW-1:0] wfall,
  output logic [DW-1:0] rrise,
  output logic [DW-1:0] rfall
);

  logic [DW-1:0] mem [2**AW];
  int            errs;
  logic [DW-1:0] last_rise;
  logic          s0_rd, s0_wr, s1_rd, s1_wr, s2_rd;
  logic [AW-1:0] s0_a, s1_a, s2_a;

  function automatic logic [AW-1:0] first_idx(input logic [AW-1:0] a);
    return LSB_START ? a : {a[AW-1:1], 1'b0};
  endfunction

  function automatic logic [AW-1:0] second_idx(input logic [AW-1:0] a);
    return first_idx(a) ^ AW'(1);
  endfunction

  initial begin
    errs = 0;
    last_rise = '0;
    s0_rd = 0; s0_wr = 0; s1_rd = 0; s1_wr = 0; s2_rd = 0;
    s0_a = '0; s1_a = '0; s2_a = '0;
    rrise = '1;
    rfall = '1;
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    s2_rd = s1_rd; s2_a = s1_a;
    s1_rd = s0_rd; s1_wr = s0_wr; s1_a = s0_a;
    s0_rd = !rd_n; s0_wr = !wr_n; s0_a = addr;
    if (s1_wr) begin
      if (!oe) errs++;
      mem[first_idx(s1_a)]  = wrise;
      mem[second_idx(s1_a)] = wfall;
      last_rise = wrise;
    end
    if (s1_rd && oe) errs++;
    if (HALF_LAT && s2_rd && oe) errs++;
    rrise = '1;
    rfall = '1;
    if (HALF_LAT) begin
      if (s1_rd) rfall = mem[first_idx(s1_a)];
      if (s2_rd) rrise = mem[second_idx(s2_a)];
    end else if (s1_rd) begin
      rrise = mem[first_idx(s1_a)];
      rfall = mem[second_idx(s1_a)];
    end
  end

endmodule

module sram_b2_ctrl_test;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned NV = 11;
  localparam time         TCK = 4ns;

  // {we, addr, word0, word1}; for reads the words are the expected result.
  localparam logic [AW+2*DW:0] VEC [NV] = '{
    {1'b1, 8'h10, 16'hA001, 16'hA002},
    {1'b1, 8'h13, 16'hB001, 16'hB002},
    {1'b0, 8'h10, 16'hA001, 16'hA002},
    {1'b0, 8'h11, 16'hA001, 16'hA002},
    {1'b0, 8'h12, 16'hB001, 16'hB002},
    {1'b1, 8'h21, 16'hC001, 16'hC002},
    {1'b0, 8'h21, 16'hC001, 16'hC002},
    {1'b0, 8'h20, 16'hC001, 16'hC002},
    {1'b1, 8'h10, 16'hD001, 16'hD002},
    {1'b0, 8'h11, 16'hD001, 16'hD002},
    {1'b0, 8'h13, 16'hB001, 16'hB002}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wd0, req_wd1;

  logic          rdy_w, rdy_n;
  logic          rv_w, rv_n;
  logic [DW-1:0] r0_w, r1_w, r0_n, r1_n;
  logic [AW-1:0] ma_w, ma_n;
  logic          rdn_w, wrn_w, oe_w, rdn_n, wrn_n, oe_n;
  logic [DW-1:0] wr_w, wf_w, wr_n_d, wf_n_d;
  logic [DW-1:0] rr_w, rf_w, rr_n, rf_n;

  int  n_chk;
  int  n_bad;
  bit  done;

  longint      due_w[$], due_n[$];
  logic [31:0] exp_w[$], exp_n[$];

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  sram_b2_ctrl #(.AW(AW), .DW(DW), .LSB_START(1'b1), .HALF_LAT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w),
    .req_we(req_we), .req_addr(req_addr), .req_wd0(req_wd0), .req_wd1(req_wd1),
    .rsp_valid(rv_w), .rsp_rd0(r0_w), .rsp_rd1(r1_w),
    .mem_addr(ma_w), .mem_rd_n(rdn_w), .mem_wr_n(wrn_w), .mem_oe(oe_w),
    .mem_wdq_rise(wr_w), .mem_wdq_fall(wf_w),
    .mem_rdq_rise(rr_w), .mem_rdq_fall(rf_w)
  );

  sram_b2_mem_model #(.AW(AW), .DW(DW), .LSB_START(1'b1), .HALF_LAT(1'b1)) mdl_w (
    .clk(clk), .addr(ma_w), .rd_n(rdn_w), .wr_n(wrn_w), .oe(oe_w),
    .wrise(wr_w), .wfall(wf_w), .rrise(rr_w), .rfall(rf_w)
  );

  sram_b2_ctrl #(.AW(AW), .DW(DW), .LSB_START(1'b0), .HALF_LAT(1'b0)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_n),
    .req_we(req_we), .req_addr(req_addr), .req_wd0(req_wd0), .req_wd1(req_wd1),
    .rsp_valid(rv_n), .rsp_rd0(r0_n), .rsp_rd1(r1_n),
    .mem_addr(ma_n), .mem_rd_n(rdn_n), .mem_wr_n(wrn_n), .mem_oe(oe_n),
    .mem_wdq_rise(wr_n_d), .mem_wdq_fall(wf_n_d),
    .mem_rdq_rise(rr_n), .mem_rdq_fall(rf_n)
  );

  sram_b2_mem_model #(.AW(AW), .DW(DW), .LSB_START(1'b0), .HALF_LAT(1'b0)) mdl_n (
    .clk(clk), .addr(ma_n), .rd_n(rdn_n), .wr_n(wrn_n), .oe(oe_n),
    .wrise(wr_n_d), .wfall(wf_n_d), .rrise(rr_n), .rfall(rf_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge inside the command cycle.
  task automatic do_req(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    longint t;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wd0   = we ? d0 : '0;
    req_wd1   = we ? d1 : '0;
    for (int i = 0; i < 16; i++) begin
      #1;
      if (rdy_w) break;
      @(negedge clk);
    end
    chk("R2 ready agreement", {63'd0, rdy_n}, {63'd0, rdy_w});
    @(posedge clk);
    t = $time;
    if (!we) begin
      due_w.push_back(t + 3 * TCK / 1ns + TCK / 2 / 1ns);
      due_n.push_back(t + 2 * TCK / 1ns + TCK / 2 / 1ns);
      exp_w.push_back({d0, d1});
      exp_n.push_back({d0, d1});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Response monitor: order, data and timing (R6, R7, R10).
  always @(negedge clk) begin
    if (rst_n && rv_w) begin
      if (due_w.size() == 0) chk("R7 wide unexpected response", 64'd1, 64'd0);
      else begin
        chk("R6 wide response time", 64'($time / 1ns), 64'(due_w.pop_front()));
        chk("R7 R10 wide response data", {32'd0, r0_w, r1_w}, {32'd0, exp_w.pop_front()});
      end
    end
    if (rst_n && rv_n) begin
      if (due_n.size() == 0) chk("R7 narrow unexpected response", 64'd1, 64'd0);
      else begin
        chk("R6 narrow response time", 64'($time / 1ns), 64'(due_n.pop_front()));
        chk("R7 R10 narrow response data", {32'd0, r0_n, r1_n}, {32'd0, exp_n.pop_front()});
      end
    end
  end

  initial begin
    #(TCK * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic r0, r1, prev;
    n_chk = 0; n_bad = 0; done = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wd0 = '0; req_wd1 = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 strobes in reset", {60'd0, rdn_w, wrn_w, rdn_n, wrn_n}, 64'hF);
    chk("R1 oe/rsp in reset", {60'd0, oe_w, rv_w, oe_n, rv_n}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {60'd0, rdn_w, wrn_w, oe_w, rv_w}, 64'hC);

    // R2: idle ready alternates and selects exactly one type
    prev = 1'b0;
    for (int i = 0; i < 4; i++) begin
      req_we = 1'b0; #1 r0 = rdy_w;
      req_we = 1'b1; #1 r1 = rdy_w;
      chk("R2 one type ready", {63'd0, r1}, {63'd0, ~r0});
      if (i > 0) chk("R2 ready toggles", {63'd0, r0}, {63'd0, ~prev});
      prev = r0;
      @(negedge clk);
    end

    // Main vector table
    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][AW+2*DW], VEC[v][AW+2*DW-1:2*DW], VEC[v][2*DW-1:DW], VEC[v][DW-1:0]);
    end
    repeat (8) @(negedge clk);

    // R4 R5: write command and data cycle, start word from LSB
    do_req(1'b1, 8'h31, 16'h1111, 16'h2222);
    chk("R4 write strobe/addr", {55'd0, wrn_w, ma_w}, {55'd0, 1'b0, 8'h31});
    #1 chk("R3 ready low in strobe cycle", {63'd0, rdy_w}, 64'd0);
    @(negedge clk);
    chk("R4 oe in data cycle", {62'd0, oe_w, oe_n}, 64'h3);
    chk("R5 wide rise/fall", {32'd0, wr_w, wf_w}, {32'd0, 16'h2222, 16'h1111});
    chk("R5 narrow rise/fall", {32'd0, wr_n_d, wf_n_d}, {32'd0, 16'h1111, 16'h2222});
    @(negedge clk);
    chk("R4 oe drops after data", {62'd0, oe_w, oe_n}, 64'h0);
    chk("R10 wide stored word0", {48'd0, mdl_w.mem[8'h30]}, {48'd0, 16'h1111});
    chk("R10 wide stored word1", {48'd0, mdl_w.mem[8'h31]}, {48'd0, 16'h2222});

    // R3 R8: read, then probe the opposite type in the strobe cycle
    mdl_w.mem[8'h40] = 16'h5555; mdl_w.mem[8'h41] = 16'h6666;
    mdl_n.mem[8'h40] = 16'h5555; mdl_n.mem[8'h41] = 16'h6666;
    do_req(1'b0, 8'h41, 16'h5555, 16'h6666);
    chk("R4 read strobe/addr", {55'd0, rdn_w, ma_w}, {55'd0, 1'b0, 8'h41});
    req_we = 1'b1;
    #1 chk("R3 write blocked after read", {62'd0, rdy_w, rdy_n}, 64'd0);
    @(negedge clk);
    chk("R8 bus released", {62'd0, oe_w, oe_n}, 64'd0);
    chk("R9 strobes high after command", {62'd0, rdn_w, wrn_w}, 64'h3);
    do_req(1'b1, 8'h40, 16'h7777, 16'h8888);
    do_req(1'b0, 8'h40, 16'h7777, 16'h8888);
    do_req(1'b0, 8'h41, 16'h7777, 16'h8888);

    // R9: quiet bus when no request
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R9 idle strobes", {60'd0, rdn_w, wrn_w, rdn_n, wrn_n}, 64'hF);
      @(negedge clk);
    end

    chk("R7 all responses returned", 64'(due_w.size() + due_n.size()), 64'd0);
    chk("R8 wide bus contention", 64'(mdl_w.errs), 64'd0);
    chk("R8 narrow bus contention", 64'(mdl_n.errs), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule